// File: doc/BRIEF.md
# Command Slot Issue Scanner

This block sits in one port of a serial storage host adapter and decides which command slot goes to the command engine next. Software sets bits in a command-issue mask. The scanner offers the lowest-numbered pending slot to the engine over a valid/ready handshake, and only one slot is outstanding at a time. After the engine accepts a slot, the scanner samples the engine's busy and data-request flags. If both are clear, the command has finished and its issue bit is cleared. If either is set, the slot is parked as the single running slot. It keeps its issue bit and blocks further dispatch until a completion pulse arrives while both flags are clear.

Queued commands are tracked by tag, apart from the issue mask. A queued start names its tag in a tag byte, and a tag already in use is refused. A queued completion releases the tag and drops it from the active mask. An error completion also sets the tag's bit in an error mask. Software may set active bits by writing ones. A read of the active mask hides, and then removes, the bits of every tag that has finished since the previous read.

Top module: `cmd_slot_scanner`

## Requirements
- R1: While rst_n is low at a clock edge, the issue mask, active mask, error mask and finished-tag record become zero. After that edge the block makes no offer, no slot is parked and no reject pulse is shown.
- R2: A write to the issue mask ORs issue_wr_data into the mask. A write never clears a bit.
- R3: Of the pending slots, the lowest-numbered one is offered first, so a set of pending slots is dispatched in ascending slot order.
- R4: A new offer starts only on a clock edge at which port_start is 1, the issue mask is nonzero, and eng_busy and eng_drq are both 0.
- R5: If eng_busy and eng_drq are both 0 on the edge after the handshake, the accepted slot's issue bit is cleared. Scanning then resumes.
- R6: If eng_busy or eng_drq is 1 on the edge after the handshake, the slot is parked. busy_slot_valid is then 1, busy_slot holds the slot number, the issue bit stays set, and no other slot is offered. The parked slot's bit is cleared and the park is released only on an eng_done pulse with eng_busy and eng_drq both 0.
- R7: While disp_valid is 1 and disp_ready is 0, disp_valid stays 1 and disp_slot holds its value.
- R8: A queued start takes its tag from bits [7:3] of ncq_tag_byte. A start whose tag is still in use from an earlier start raises ncq_reject for one cycle on the following edge and changes no mask.
- R9: A queued completion clears the active bit of ncq_done_tag and releases that tag for a new start. With ncq_done_err set, it also sets err_mask bit ncq_done_tag.
- R10: An active write sets the bits of act_wr_data (write-1-to-set). During a read, act_rd_data equals the active mask without the tags that have finished since the previous read, and those bits are removed from the active mask at the read's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_wr_en | input | 1 | Write strobe for the issue mask |
| issue_wr_data | input | 32 | Bits to OR into the issue mask |
| port_start | input | 1 | Port started; enables dispatch |
| eng_busy | input | 1 | Engine busy flag |
| eng_drq | input | 1 | Engine data-request flag |
| eng_done | input | 1 | Completion pulse for the parked command |
| disp_ready | input | 1 | Engine accepts the offered slot |
| disp_valid | output | 1 | A slot is offered |
| disp_slot | output | 5 | Offered slot number |
| busy_slot_valid | output | 1 | A slot is parked as running |
| busy_slot | output | 5 | Parked slot number |
| issue_mask | output | 32 | Current issue mask |
| ncq_start | input | 1 | Queued command start |
| ncq_tag_byte | input | 8 | Tag byte; tag in bits [7:3] |
| ncq_done | input | 1 | Queued command completion |
| ncq_done_tag | input | 5 | Tag of the completing command |
| ncq_done_err | input | 1 | Completion ended in error |
| act_wr_en | input | 1 | Active-mask write strobe |
| act_wr_data | input | 32 | Bits to set in the active mask |
| act_rd_en | input | 1 | Active-mask read strobe |
| act_rd_data | output | 32 | Active mask as returned by a read |
| act_mask | output | 32 | Current active mask |
| err_mask | output | 32 | Per-tag error bits |
| ncq_reject | output | 1 | Start refused, tag already in use |

## Verification
A wrong dispatch state shows as an offer that starts while the engine is busy. It can also show as a slot number that skips a lower pending bit, or as an offer that moves before it is accepted. Each of these is visible on disp_valid and disp_slot one edge after the faulty decision. A mishandled park or clear shows on issue_mask and busy_slot_valid on the edge after the handshake or after the completion pulse: a bit lingers, vanishes too early, or a second slot is offered. A wrong tag record shows as a missing or spurious ncq_reject, or as act_rd_data still carrying a finished tag, on the very next read.

// File: rtl/cs_pkg.sv
// Shared types for the command slot issue scanner.
package cs_pkg;
    // Dispatch sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a dispatch opportunity
        ST_OFFER = 2'd1,   // slot presented to the engine
        ST_CHECK = 2'd2,   // sampling engine flags after acceptance
        ST_PARK  = 2'd3    // slot still running in the engine
    } disp_state_e;
endpackage

// File: rtl/cs_lowest_pick.sv
// Lowest-index picker.
// Reports whether any request bit is set and gives the index of the lowest
// set bit. Assumes N >= 2. Purely combinational.
module cs_lowest_pick #(
    parameter int N = 32,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    // Walk from the top so the lowest set bit is the last one written.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/cs_dispatch.sv
// Issue mask and single-outstanding dispatch sequencer.
// Holds the issue mask, offers the lowest pending slot when the port is
// started and the engine is idle, then clears or parks that slot according
// to the engine flags sampled one edge after acceptance.
// Assumes eng_done is a pulse for the parked command only.
module cs_dispatch
    import cs_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_wr_en,
    input  logic [NUM_SLOTS-1:0] issue_wr_data,
    input  logic                 port_start,
    input  logic                 eng_busy,
    input  logic                 eng_drq,
    input  logic                 eng_done,
    input  logic                 disp_ready,
    output logic                 disp_valid,
    output logic [SLOT_W-1:0]    disp_slot,
    output logic                 busy_slot_valid,
    output logic [SLOT_W-1:0]    busy_slot,
    output logic [NUM_SLOTS-1:0] issue_mask
);
    logic [NUM_SLOTS-1:0] issue_q, issue_d, clr_vec;
    logic [SLOT_W-1:0]    slot_q, slot_d, pick_idx;
    logic                 pick_found, hold;
    disp_state_e          state_q, state_d;

    assign hold = eng_busy | eng_drq;

    cs_lowest_pick #(.N(NUM_SLOTS)) u_pick (
        .req   (issue_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Decide which issue bit, if any, is retired this cycle.
    always_comb begin
        clr_vec = '0;
        if ((state_q == ST_CHECK) && !hold)
            clr_vec[slot_q] = 1'b1;
        if ((state_q == ST_PARK) && eng_done && !hold)
            clr_vec[slot_q] = 1'b1;
    end

    // Software writes only add bits; retirement removes them afterwards.
    always_comb begin
        issue_d = issue_q;
        if (issue_wr_en) issue_d = issue_d | issue_wr_data;
        issue_d = issue_d & ~clr_vec;
    end

    // Sequencer next-state logic.
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            ST_IDLE: if (port_start && pick_found && !hold) begin
                state_d = ST_OFFER;
                slot_d  = pick_idx;
            end
            ST_OFFER: if (disp_ready) state_d = ST_CHECK;
            ST_CHECK: state_d = hold ? ST_PARK : ST_IDLE;
            ST_PARK:  if (eng_done && !hold) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, slot and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            issue_q <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            issue_q <= issue_d;
        end
    end

    assign disp_valid      = (state_q == ST_OFFER);
    assign disp_slot       = slot_q;
    assign busy_slot_valid = (state_q == ST_PARK);
    assign busy_slot       = slot_q;
    assign issue_mask      = issue_q;

    // R1: reset empties the mask and idles the sequencer.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (issue_q == '0) && !disp_valid && !busy_slot_valid);

    // R3: an offered slot is always a pending one.
    p_offer_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> issue_q[disp_slot]);

    // R4: an offer begins only when started and the engine is idle.
    p_offer_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_valid) |-> $past(port_start && !eng_busy && !eng_drq));

    // R5: a command that finished at once loses its issue bit.
    p_retire_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK) && !hold |=> !issue_q[$past(slot_q)]);

    // R6: a parked slot keeps its issue bit.
    p_park_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_slot_valid |-> issue_q[busy_slot]);

    // R7: the offer holds still until accepted.
    p_offer_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_slot));
endmodule

// File: rtl/cs_tag_tracker.sv
// Queued-command tag tracker.
// Keeps per-tag in-use, active, finished-since-read and error bits. A start
// on a tag in use is refused with a one-cycle reject pulse. Assumes at most
// one start and one completion per cycle.
module cs_tag_tracker #(
    parameter int NUM_TAGS = 32,
    parameter int TAG_LSB  = 3,
    parameter int BYTE_W   = 8,
    localparam int TAG_W = $clog2(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ncq_start,
    input  logic [BYTE_W-1:0]   ncq_tag_byte,
    input  logic                ncq_done,
    input  logic [TAG_W-1:0]    ncq_done_tag,
    input  logic                ncq_done_err,
    input  logic                act_wr_en,
    input  logic [NUM_TAGS-1:0] act_wr_data,
    input  logic                act_rd_en,
    output logic [NUM_TAGS-1:0] act_rd_data,
    output logic [NUM_TAGS-1:0] act_mask,
    output logic [NUM_TAGS-1:0] err_mask,
    output logic                ncq_reject
);
    logic [TAG_W-1:0]    start_tag;
    logic [NUM_TAGS-1:0] inuse_q, act_q, fin_q, err_q;
    logic                reject_q;
    logic                unused_low;

    assign start_tag  = ncq_tag_byte[TAG_LSB +: TAG_W];
    assign unused_low = ^ncq_tag_byte[TAG_LSB-1:0];

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
        logic start_hit, done_hit, wr_hit;
        assign start_hit = ncq_start && (start_tag == TAG_W'(t));
        assign done_hit  = ncq_done && (ncq_done_tag == TAG_W'(t));
        assign wr_hit    = act_wr_en && act_wr_data[t];

        // Per-tag state: occupancy, active, finished record, error.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                inuse_q[t] <= 1'b0;
                act_q[t]   <= 1'b0;
                fin_q[t]   <= 1'b0;
                err_q[t]   <= 1'b0;
            end else begin
                inuse_q[t] <= (inuse_q[t] | start_hit) & ~done_hit;
                act_q[t]   <= (((act_rd_en ? (act_q[t] & ~fin_q[t]) : act_q[t])
                               | wr_hit) & ~done_hit);
                fin_q[t]   <= act_rd_en ? done_hit : (fin_q[t] | done_hit);
                err_q[t]   <= err_q[t] | (done_hit & ncq_done_err);
            end
        end
    end

    // Reject pulse for a start on an occupied tag.
    always_ff @(posedge clk) begin
        if (!rst_n) reject_q <= 1'b0;
        else        reject_q <= ncq_start && inuse_q[start_tag];
    end

    assign act_rd_data = act_q & ~fin_q;
    assign act_mask    = act_q;
    assign err_mask    = err_q;
    assign ncq_reject  = reject_q;

    // R8: a start on an occupied tag is refused on the next edge.
    p_dup_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ncq_start && inuse_q[start_tag] |=> ncq_reject);

    // R9: completion drops the active bit; an error completion flags it.
    p_done_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ncq_done |=> !act_q[$past(ncq_done_tag)] && !inuse_q[$past(ncq_done_tag)]);
    p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ncq_done && ncq_done_err |=> err_q[$past(ncq_done_tag)]);

    // R10: a read strips every tag finished before it.
    p_read_strips_r10: assert property (@(posedge clk) disable iff (!rst_n)
        act_rd_en && !act_wr_en |=> (act_q & $past(fin_q)) == '0);
endmodule

// File: rtl/cmd_slot_scanner.sv
// Command slot issue scanner, per-port top level.
// Joins the issue-mask dispatch sequencer and the queued-command tag
// tracker. The two halves share only clock and reset.
module cmd_slot_scanner #(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_TAGS  = 32,
    parameter int TAG_LSB   = 3,
    parameter int BYTE_W    = 8,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int TAG_W  = $clog2(NUM_TAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_wr_en,
    input  logic [NUM_SLOTS-1:0] issue_wr_data,
    input  logic                 port_start,
    input  logic                 eng_busy,
    input  logic                 eng_drq,
    input  logic                 eng_done,
    input  logic                 disp_ready,
    output logic                 disp_valid,
    output logic [SLOT_W-1:0]    disp_slot,
    output logic                 busy_slot_valid,
    output logic [SLOT_W-1:0]    busy_slot,
    output logic [NUM_SLOTS-1:0] issue_mask,
    input  logic                 ncq_start,
    input  logic [BYTE_W-1:0]    ncq_tag_byte,
    input  logic                 ncq_done,
    input  logic [TAG_W-1:0]     ncq_done_tag,
    input  logic                 ncq_done_err,
    input  logic                 act_wr_en,
    input  logic [NUM_TAGS-1:0]  act_wr_data,
    input  logic                 act_rd_en,
    output logic [NUM_TAGS-1:0]  act_rd_data,
    output logic [NUM_TAGS-1:0]  act_mask,
    output logic [NUM_TAGS-1:0]  err_mask,
    output logic                 ncq_reject
);
    cs_dispatch #(.NUM_SLOTS(NUM_SLOTS)) u_dispatch (
        .clk             (clk),
        .rst_n           (rst_n),
        .issue_wr_en     (issue_wr_en),
        .issue_wr_data   (issue_wr_data),
        .port_start      (port_start),
        .eng_busy        (eng_busy),
        .eng_drq         (eng_drq),
        .eng_done        (eng_done),
        .disp_ready      (disp_ready),
        .disp_valid      (disp_valid),
        .disp_slot       (disp_slot),
        .busy_slot_valid (busy_slot_valid),
        .busy_slot       (busy_slot),
        .issue_mask      (issue_mask)
    );

    cs_tag_tracker #(
        .NUM_TAGS (NUM_TAGS),
        .TAG_LSB  (TAG_LSB),
        .BYTE_W   (BYTE_W)
    ) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .ncq_start    (ncq_start),
        .ncq_tag_byte (ncq_tag_byte),
        .ncq_done     (ncq_done),
        .ncq_done_tag (ncq_done_tag),
        .ncq_done_err (ncq_done_err),
        .act_wr_en    (act_wr_en),
        .act_wr_data  (act_wr_data),
        .act_rd_en    (act_rd_en),
        .act_rd_data  (act_rd_data),
        .act_mask     (act_mask),
        .err_mask     (err_mask),
        .ncq_reject   (ncq_reject)
    );
endmodule

// File: tb/cmd_slot_scanner_tb.sv
// Self-checking bench: a vector table of issue masks walked by one loop,
// then directed tests for gating, parking, tags and reset.
module cmd_slot_scanner_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_wr_en = 1'b0;
    logic [31:0] issue_wr_data = '0;
    logic        port_start = 1'b0;
    logic        eng_busy = 1'b0;
    logic        eng_drq = 1'b0;
    logic        eng_done = 1'b0;
    logic        disp_ready = 1'b0;
    logic        disp_valid;
    logic [4:0]  disp_slot;
    logic        busy_slot_valid;
    logic [4:0]  busy_slot;
    logic [31:0] issue_mask;
    logic        ncq_start = 1'b0;
    logic [7:0]  ncq_tag_byte = '0;
    logic        ncq_done = 1'b0;
    logic [4:0]  ncq_done_tag = '0;
    logic        ncq_done_err = 1'b0;
    logic        act_wr_en = 1'b0;
    logic [31:0] act_wr_data = '0;
    logic        act_rd_en = 1'b0;
    logic [31:0] act_rd_data;
    logic [31:0] act_mask;
    logic [31:0] err_mask;
    logic        ncq_reject;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmd_slot_scanner u_dut (
        .clk(clk), .rst_n(rst_n),
        .issue_wr_en(issue_wr_en), .issue_wr_data(issue_wr_data),
        .port_start(port_start), .eng_busy(eng_busy), .eng_drq(eng_drq),
        .eng_done(eng_done), .disp_ready(disp_ready),
        .disp_valid(disp_valid), .disp_slot(disp_slot),
        .busy_slot_valid(busy_slot_valid), .busy_slot(busy_slot),
        .issue_mask(issue_mask),
        .ncq_start(ncq_start), .ncq_tag_byte(ncq_tag_byte),
        .ncq_done(ncq_done), .ncq_done_tag(ncq_done_tag),
        .ncq_done_err(ncq_done_err),
        .act_wr_en(act_wr_en), .act_wr_data(act_wr_data),
        .act_rd_en(act_rd_en), .act_rd_data(act_rd_data),
        .act_mask(act_mask), .err_mask(err_mask), .ncq_reject(ncq_reject)
    );

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] first;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h0000_0001, 32'd0},
        '{32'h8000_0000, 32'd31},
        '{32'h0001_0104, 32'd2},
        '{32'hA000_0003, 32'd0}
    };

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lowest(input logic [31:0] m);
        logic [31:0] r = 32'd0;
        for (int i = 31; i >= 0; i--) if (m[i]) r = i;
        return r;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic issue_write(input logic [31:0] v);
        issue_wr_en = 1'b1; issue_wr_data = v;
        step();
        issue_wr_en = 1'b0; issue_wr_data = '0;
    endtask

    task automatic wait_offer(input string req);
        for (int k = 0; k < 20; k++) begin
            if (disp_valid) break;
            step();
        end
        chk(req, {31'd0, disp_valid}, 32'd1);
    endtask

    // Accept the current offer with the engine idle; leaves the bit retired.
    task automatic accept_clean();
        disp_ready = 1'b1;
        step();
        disp_ready = 1'b0;
        step();
    endtask

    initial begin
        logic [31:0] model;
        step(); step();
        // R1: state right after reset.
        chk("R1 issue", issue_mask, 32'd0);
        chk("R1 active", act_mask, 32'd0);
        chk("R1 err", err_mask, 32'd0);
        chk("R1 idle", {29'd0, disp_valid, busy_slot_valid, ncq_reject}, 32'd0);
        rst_n = 1'b1;
        port_start = 1'b1;
        step();

        // R3 / R5: table of masks drained in ascending order.
        for (int v = 0; v < 4; v++) begin
            model = VECS[v].mask;
            issue_write(model);
            wait_offer("R3 offer");
            chk("R3 first", {27'd0, disp_slot}, VECS[v].first);
            while (model != 0) begin
                wait_offer("R3 offer");
                chk("R3 order", {27'd0, disp_slot}, lowest(model));
                model[lowest(model)] = 1'b0;
                accept_clean();
                chk("R5 retire", issue_mask, model);
            end
        end

        // R2 / R4: writes OR in while the port is stopped; no offer.
        port_start = 1'b0;
        issue_write(32'h1);
        issue_write(32'h4);
        issue_write(32'h0);
        step(); step();
        chk("R2 or", issue_mask, 32'h5);
        chk("R4 stopped", {31'd0, disp_valid}, 32'd0);
        eng_busy = 1'b1; port_start = 1'b1;
        step(); step(); step();
        chk("R4 busy", {31'd0, disp_valid}, 32'd0);
        eng_busy = 1'b0; eng_drq = 1'b1;
        step(); step();
        chk("R4 drq", {31'd0, disp_valid}, 32'd0);
        eng_drq = 1'b0;
        step(); step();
        chk("R4 release", {31'd0, disp_valid}, 32'd1);
        chk("R4 slot", {27'd0, disp_slot}, 32'd0);

        // R7: offer held without ready.
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R7 hold", {26'd0, disp_valid, disp_slot}, {26'd0, 1'b1, 5'd0});
        end

        // R6: accept, engine stays busy, slot parks.
        disp_ready = 1'b1;
        step();
        disp_ready = 1'b0; eng_busy = 1'b1;
        step();
        chk("R6 parked", {26'd0, busy_slot_valid, busy_slot}, {26'd0, 1'b1, 5'd0});
        chk("R6 keeps bit", issue_mask, 32'h5);
        chk("R6 no offer", {31'd0, disp_valid}, 32'd0);
        eng_done = 1'b1;
        step();
        eng_done = 1'b0;
        step();
        chk("R6 done while busy", {31'd0, busy_slot_valid}, 32'd1);
        eng_busy = 1'b0;
        step(); step();
        chk("R6 no done yet", {30'd0, busy_slot_valid, disp_valid}, 32'h2);
        eng_done = 1'b1;
        step();
        eng_done = 1'b0;
        chk("R6 release", issue_mask, 32'h4);
        chk("R6 unparked", {31'd0, busy_slot_valid}, 32'd0);
        wait_offer("R3 resume");
        chk("R3 resume slot", {27'd0, disp_slot}, 32'd2);
        accept_clean();
        chk("R5 empty", issue_mask, 32'd0);

        // R8 / R9: tag 5 from byte 0x2B, duplicate refused, error completion.
        act_wr_en = 1'b1; act_wr_data = 32'h0000_0020;
        step();
        act_wr_en = 1'b0; act_wr_data = '0;
        chk("R10 w1s", act_mask, 32'h20);
        ncq_start = 1'b1; ncq_tag_byte = 8'h2B;
        step();
        ncq_start = 1'b0;
        chk("R8 first ok", {31'd0, ncq_reject}, 32'd0);
        ncq_start = 1'b1; ncq_tag_byte = 8'h28;
        step();
        ncq_start = 1'b0;
        chk("R8 dup reject", {31'd0, ncq_reject}, 32'd1);
        chk("R8 masks same", act_mask ^ err_mask, 32'h20);
        step();
        chk("R8 pulse", {31'd0, ncq_reject}, 32'd0);
        ncq_done = 1'b1; ncq_done_tag = 5'd5; ncq_done_err = 1'b1;
        step();
        ncq_done = 1'b0; ncq_done_err = 1'b0;
        chk("R9 act cleared", act_mask, 32'd0);
        chk("R9 err set", err_mask, 32'h20);
        ncq_start = 1'b1; ncq_tag_byte = 8'h28;
        step();
        ncq_start = 1'b0;
        chk("R9 tag freed", {31'd0, ncq_reject}, 32'd0);

        // R10: tag 9 finishes, is set again by software, hidden by the read.
        ncq_start = 1'b1; ncq_tag_byte = 8'h48;
        step();
        ncq_start = 1'b0;
        ncq_done = 1'b1; ncq_done_tag = 5'd9;
        step();
        ncq_done = 1'b0;
        act_wr_en = 1'b1; act_wr_data = 32'h0000_0204;
        step();
        act_wr_en = 1'b0; act_wr_data = '0;
        chk("R10 set", act_mask, 32'h204);
        act_rd_en = 1'b1;
        #1;
        chk("R10 read strips", act_rd_data, 32'h004);
        step();
        act_rd_en = 1'b0;
        chk("R10 removed", act_mask, 32'h004);
        act_wr_en = 1'b1; act_wr_data = 32'h0000_0200;
        step();
        act_wr_en = 1'b0; act_wr_data = '0;
        act_rd_en = 1'b1;
        #1;
        chk("R10 record cleared", act_rd_data, 32'h204);
        step();
        act_rd_en = 1'b0;

        // R1: reset in the middle of activity.
        port_start = 1'b0;
        issue_write(32'h0000_00F0);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk("R1 mid issue", issue_mask, 32'd0);
        chk("R1 mid tags", act_mask | err_mask, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule